// File: doc/BRIEF.md
# Comparator Output Change Interrupt

This block watches the digital decisions of two analog comparators and turns any change in them into a sticky interrupt flag. Each channel can be inverted, and a 3-bit mode field switches both channels off. The resulting live outputs are visible as status bits on a small register port. The block keeps a snapshot of the outputs as they were at the last access to the control/status register. The flag is raised every cycle that the live outputs disagree with that snapshot, so software has to touch the register before a clear can stick.

The flag drives an interrupt request through three enables: a local enable held in the flag register, plus peripheral and global enables that come in as inputs. In a low-power state a set and locally enabled flag raises a wake request. The register contents are not disturbed by that state.

The register port has two addresses. The address input at 0 selects the control/status register and at 1 selects the flag register. Reads are combinational, and writes take effect at the clock edge.

Top module: `cmp_chg_irq`

## Requirements
- R1: After reset, the mode field is 111, both inverts are 0, the status bits are 0 and the flag and local enable are 0. The interrupt and wake outputs are 0.
- R2: While the mode field is 111, both status bits read 0 whatever the raw inputs and invert bits are.
- R3: While the mode field is not 111, status bit i equals raw input i XOR invert bit i.
- R4: A read at address 0 returns bit 7 = status 2, bit 6 = status 1, bit 5 = invert 2, bit 4 = invert 1, bit 3 = 0 and bits 2:0 = mode. A read at address 1 returns bit 1 = local enable, bit 0 = flag and 0 elsewhere. Writes use the same positions, and a written bit 3 is discarded.
- R5: A cycle in which the status bits differ from the snapshot, with no address-0 access in that cycle, sets the flag at the next clock edge, for a change on either channel.
- R6: Any read or write at address 0 loads the snapshot with the status bits of that cycle and ends the mismatch. A flag cleared afterwards stays clear.
- R7: While a mismatch persists, writing 0 to the flag does not clear it, because setting takes priority over clearing.
- R8: Writing 1 to flag bit 0 sets the flag with no comparator change.
- R9: The interrupt output is 1 only when the flag, the local enable, the peripheral enable and the global enable are all 1.
- R10: The flag is set by a mismatch even when all enables are 0.
- R11: If the status bits change in the same cycle as an address-0 read, the flag is not set. The snapshot takes the new value and the read returns it.
- R12: The wake output is 1 when the low-power input, the flag and the local enable are all 1. The low-power input alters no register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_raw_i | input | 2 | Raw comparator decisions, bit 0 = channel 1 |
| reg_sel_i | input | 1 | Register address: 0 control/status, 1 flag |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, 0 when no read |
| periph_en_i | input | 1 | Peripheral interrupt enable |
| glob_en_i | input | 1 | Global interrupt enable |
| sleep_i | input | 1 | Low-power state indicator |
| cmp_out_o | output | 2 | Live status bits after gating and inversion |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
A stale or wrongly loaded snapshot shows up as a flag that is set or missing one clock after the offending cycle. It can be read back at address 1 in the next cycle. A broken set-over-clear priority shows when a flag cleared during a persisting mismatch reads 1 or 0 on the following read. Errors in the polarity or mode gating show on the status port in the same cycle and in the address-0 read. Enable-gate faults show on the interrupt and wake outputs in the cycle after the enabling write.

// File: rtl/cmp_chg_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the comparator change interrupt block.
// Assumes exactly two channels, because the register layout packs two status
// and two invert bits.
package cmp_chg_pkg;
    localparam int NCH    = 2;
    localparam int MODE_W = 3;
    localparam int DW     = 8;
    localparam logic [MODE_W-1:0] MODE_OFF = 3'b111;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_FLAG = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [NCH-1:0]    inv;
        logic [MODE_W-1:0] mode;
    } ctrl_t;
endpackage

// File: rtl/cmp_polarity.sv
`timescale 1ns/1ps
// Applies the mode gate and per-channel inversion to the raw comparator bits.
// Assumes raw inputs are already synchronous to clk. Channels that are off
// read 0 and are not inverted.
module cmp_polarity
    import cmp_chg_pkg::*;
(
    input  logic [NCH-1:0] raw_i,
    input  ctrl_t          ctrl_i,
    output logic [NCH-1:0] live_o
);
    logic chan_on;

    // Both channels share one mode field; 111 turns them off.
    assign chan_on = (ctrl_i.mode != MODE_OFF);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        // Gate first, then invert only an active channel.
        always_comb live_o[ch] = chan_on ? (raw_i[ch] ^ ctrl_i.inv[ch]) : 1'b0;
    end
endmodule

// File: rtl/cmp_ctrl_regs.sv
`timescale 1ns/1ps
// Holds the mode/invert register, decodes the register port and forms read data.
// Assumes single-cycle strobes. An address-0 read or write is reported as an
// access so that the snapshot can reload.
module cmp_ctrl_regs
    import cmp_chg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_i,
    input  logic           rd_i,
    input  logic           wr_i,
    input  logic [5:0]     wdata_i,
    input  logic [NCH-1:0] live_i,
    input  logic           flag_i,
    input  logic           cie_i,
    output ctrl_t          ctrl_o,
    output logic           acc_ctrl_o,
    output logic           wr_flag_o,
    output logic [DW-1:0]  rdata_o
);
    localparam int PAD_W = DW - 2;

    logic wr_ctrl;

    // Address decode for both registers.
    assign wr_ctrl    = wr_i && (sel_i == SEL_CTRL);
    assign wr_flag_o  = wr_i && (sel_i == SEL_FLAG);
    assign acc_ctrl_o = (rd_i || wr_i) && (sel_i == SEL_CTRL);

    // Control register: mode and invert bits, reset to channels off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o.mode <= MODE_OFF;
            ctrl_o.inv  <= '0;
        end else if (wr_ctrl) begin
            ctrl_o.mode <= wdata_i[MODE_W-1:0];
            ctrl_o.inv  <= wdata_i[5:4];
        end
    end

    // Read mux: status, inverts, zero, mode; or the enable and flag.
    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            if (sel_i == SEL_CTRL)
                rdata_o = {live_i[1], live_i[0], ctrl_o.inv[1], ctrl_o.inv[0], 1'b0, ctrl_o.mode};
            else
                rdata_o = {{PAD_W{1'b0}}, cie_i, flag_i};
        end
    end
endmodule

// File: rtl/cmp_change_det.sv
`timescale 1ns/1ps
// Keeps the snapshot of the status bits taken at the last control-register
// access and reports a set event on mismatch. Assumes that an access in the
// same cycle overrides the set, so the reload wins.
module cmp_change_det
    import cmp_chg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] live_i,
    input  logic           acc_ctrl_i,
    output logic [NCH-1:0] snap_o,
    output logic           set_evt_o
);
    // Snapshot register, reloaded from the live bits on any access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_o <= '0;
        else if (acc_ctrl_i)
            snap_o <= live_i;
    end

    // Any channel differing raises a set event unless an access is under way.
    assign set_evt_o = (|(live_i ^ snap_o)) && !acc_ctrl_i;
endmodule

// File: rtl/cmp_flag_gate.sv
`timescale 1ns/1ps
// Sticky flag with software set/clear, local enable, three-way interrupt gate
// and wake request. Assumes a hardware set outranks a software clear in the
// same cycle.
module cmp_flag_gate (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_evt_i,
    input  logic       wr_flag_i,
    input  logic [1:0] wdata_i,
    input  logic       periph_en_i,
    input  logic       glob_en_i,
    input  logic       sleep_i,
    output logic       flag_o,
    output logic       cie_o,
    output logic       irq_o,
    output logic       wake_o
);
    // Flag and local enable registers; a set event wins over a written 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            cie_o  <= 1'b0;
        end else begin
            flag_o <= (wr_flag_i ? wdata_i[0] : flag_o) | set_evt_i;
            if (wr_flag_i)
                cie_o <= wdata_i[1];
        end
    end

    // Request outputs gated by their enables.
    assign irq_o  = flag_o && cie_o && periph_en_i && glob_en_i;
    assign wake_o = sleep_i && flag_o && cie_o;
endmodule

// File: rtl/cmp_chg_irq.sv
`timescale 1ns/1ps
// Top of the comparator change interrupt block: polarity gating, control
// register, snapshot compare and flag gate. Assumes synchronous raw inputs and a
// synchronous active-low reset.
module cmp_chg_irq
    import cmp_chg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmp_raw_i,
    input  logic           reg_sel_i,
    input  logic           reg_rd_i,
    input  logic           reg_wr_i,
    input  logic [DW-1:0]  reg_wdata_i,
    output logic [DW-1:0]  reg_rdata_o,
    input  logic           periph_en_i,
    input  logic           glob_en_i,
    input  logic           sleep_i,
    output logic [NCH-1:0] cmp_out_o,
    output logic           irq_o,
    output logic           wake_o
);
    ctrl_t          ctrl_q;
    logic [NCH-1:0] live;
    logic [NCH-1:0] snap_q;
    logic           acc_ctrl;
    logic           wr_flag;
    logic           set_evt;
    logic           flag_q;
    logic           cie_q;
    logic [MODE_W-1:0] mode_q;
    logic           unused_wbits;

    // Write-data bits with no storage behind them.
    assign unused_wbits = ^{reg_wdata_i[7:6], reg_wdata_i[3]};
    assign mode_q       = ctrl_q.mode;
    assign cmp_out_o    = live;

    cmp_polarity u_pol (
        .raw_i  (cmp_raw_i),
        .ctrl_i (ctrl_q),
        .live_o (live)
    );

    cmp_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (reg_sel_i),
        .rd_i       (reg_rd_i),
        .wr_i       (reg_wr_i),
        .wdata_i    (reg_wdata_i[5:0]),
        .live_i     (live),
        .flag_i     (flag_q),
        .cie_i      (cie_q),
        .ctrl_o     (ctrl_q),
        .acc_ctrl_o (acc_ctrl),
        .wr_flag_o  (wr_flag),
        .rdata_o    (reg_rdata_o)
    );

    cmp_change_det u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .live_i     (live),
        .acc_ctrl_i (acc_ctrl),
        .snap_o     (snap_q),
        .set_evt_o  (set_evt)
    );

    cmp_flag_gate u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_evt_i   (set_evt),
        .wr_flag_i   (wr_flag),
        .wdata_i     (reg_wdata_i[1:0]),
        .periph_en_i (periph_en_i),
        .glob_en_i   (glob_en_i),
        .sleep_i     (sleep_i),
        .flag_o      (flag_q),
        .cie_o       (cie_q),
        .irq_o       (irq_o),
        .wake_o      (wake_o)
    );
endmodule

// File: rtl/cmp_chg_irq_chk.sv
`timescale 1ns/1ps
// Property checker for cmp_chg_irq, attached by bind. It observes the
// control-register state, the snapshot and the flag path.
module cmp_chg_irq_chk
    import cmp_chg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode,
    input logic [NCH-1:0]    live,
    input logic [NCH-1:0]    snap,
    input logic              acc_ctrl,
    input logic              wr_flag,
    input logic              wdata0,
    input logic              flag,
    input logic              cie,
    input logic              periph_en,
    input logic              glob_en,
    input logic              sleep,
    input logic              irq,
    input logic              wake
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode == MODE_OFF && live == '0 && !flag && !cie));

    assert_off_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |-> (live == '0));

    assert_mismatch_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live != snap && !acc_ctrl) |=> flag);

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ctrl |=> (snap == $past(live)));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_flag && !wdata0)) |=> flag);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && cie && periph_en && glob_en));

    assert_no_set_on_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ctrl && !flag && !wr_flag) |=> !flag);

    assert_wake_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (sleep && flag && cie));
endmodule

bind cmp_chg_irq cmp_chg_irq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_q),
    .live      (live),
    .snap      (snap_q),
    .acc_ctrl  (acc_ctrl),
    .wr_flag   (wr_flag),
    .wdata0    (reg_wdata_i[0]),
    .flag      (flag_q),
    .cie       (cie_q),
    .periph_en (periph_en_i),
    .glob_en   (glob_en_i),
    .sleep     (sleep_i),
    .irq       (irq_o),
    .wake      (wake_o)
);

// File: tb/cmp_chg_irq_tb_top.sv
`timescale 1ns/1ps
module cmp_chg_irq_tb_top;
    localparam int K_RDATA = 0;
    localparam int K_STAT  = 1;
    localparam int K_IRQ   = 2;
    localparam int K_WAKE  = 3;

    typedef struct packed {
        logic [3:0] kind;
        logic [7:0] req;
        logic [7:0] exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] raw = 2'b00;
    logic       sel = 1'b0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       periph = 1'b0;
    logic       glob = 1'b0;
    logic       sleep = 1'b0;
    logic [1:0] stat;
    logic       irq;
    logic       wake;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    cmp_chg_irq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_raw_i   (raw),
        .reg_sel_i   (sel),
        .reg_rd_i    (rd),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .periph_en_i (periph),
        .glob_en_i   (glob),
        .sleep_i     (sleep),
        .cmp_out_o   (stat),
        .irq_o       (irq),
        .wake_o      (wake)
    );

    // Monitor: at each falling edge, compare every queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RDATA: act = rdata;
                    K_STAT:  act = {6'b0, stat};
                    K_IRQ:   act = {7'b0, irq};
                    default: act = {7'b0, wake};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_errors++;
                    $display("FAIL R%0d kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input int req, input logic [7:0] exp);
        item_t it;
        it.kind = kind[3:0];
        it.req  = req[7:0];
        it.exp  = exp;
        sb_q.push_back(it);
    endtask

    task automatic nxt();
        @(posedge clk);
        #1;
        rd = 1'b0;
        wr = 1'b0;
    endtask

    task automatic rd_chk(input logic s, input logic [7:0] exp, input int req);
        nxt();
        sel = s;
        rd = 1'b1;
        push(K_RDATA, req, exp);
    endtask

    task automatic wr_reg(input logic s, input logic [7:0] d);
        nxt();
        sel = s;
        wr = 1'b1;
        wdata = d;
    endtask

    task automatic set_raw(input logic [1:0] v);
        nxt();
        raw = v;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Driver: stimulus and expectations derived from the requirements.
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        rd_chk(1'b0, 8'h07, 1);
        push(K_STAT, 1, 8'h00);
        push(K_IRQ, 1, 8'h00);
        push(K_WAKE, 1, 8'h00);
        rd_chk(1'b1, 8'h00, 1);
        // R2: off mode hides raw inputs
        set_raw(2'b11);
        push(K_STAT, 2, 8'h00);
        rd_chk(1'b0, 8'h07, 2);
        rd_chk(1'b1, 8'h00, 2);
        // R3/R5: enable channels, change shows and sets flag
        wr_reg(1'b0, 8'h00);
        nxt();
        push(K_STAT, 3, 8'h03);
        rd_chk(1'b1, 8'h01, 5);
        push(K_IRQ, 10, 8'h00);                 // R10: enables off, no request
        rd_chk(1'b0, 8'hC0, 4);                 // R4: layout, reload
        wr_reg(1'b1, 8'h00);
        rd_chk(1'b1, 8'h00, 6);                 // R6: clear sticks after access
        // R7: clear during a persisting mismatch fails
        set_raw(2'b01);
        wr_reg(1'b1, 8'h00);
        rd_chk(1'b1, 8'h01, 7);
        rd_chk(1'b0, 8'h40, 6);
        wr_reg(1'b1, 8'h00);
        rd_chk(1'b1, 8'h00, 6);
        // R3: channel 1 inverted
        wr_reg(1'b0, 8'h10);
        nxt();
        push(K_STAT, 3, 8'h00);
        rd_chk(1'b0, 8'h10, 3);
        wr_reg(1'b1, 8'h00);
        rd_chk(1'b1, 8'h00, 3);
        // R4: bit 3 discarded; R6: access masks the mismatch
        wr_reg(1'b0, 8'h38);
        rd_chk(1'b0, 8'hB0, 4);
        rd_chk(1'b1, 8'h00, 6);
        // R11: change in the same cycle as a read
        nxt();
        raw = 2'b00;
        sel = 1'b0;
        rd = 1'b1;
        push(K_RDATA, 11, 8'hF0);
        rd_chk(1'b1, 8'h00, 11);
        // R8: software set
        wr_reg(1'b1, 8'h01);
        rd_chk(1'b1, 8'h01, 8);
        // R9: three-way gate
        wr_reg(1'b1, 8'h03);
        nxt(); periph = 1'b0; glob = 1'b1;
        push(K_IRQ, 9, 8'h00);
        nxt(); periph = 1'b1; glob = 1'b0;
        push(K_IRQ, 9, 8'h00);
        nxt(); glob = 1'b1;
        push(K_IRQ, 9, 8'h01);
        wr_reg(1'b1, 8'h02);
        nxt();
        push(K_IRQ, 9, 8'h00);
        // R12: wake request and state preserved in sleep
        wr_reg(1'b1, 8'h03);
        nxt(); sleep = 1'b1;
        push(K_WAKE, 12, 8'h01);
        rd_chk(1'b0, 8'hF0, 12);
        wr_reg(1'b1, 8'h02);
        nxt();
        push(K_WAKE, 12, 8'h00);
        nxt(); sleep = 1'b0;
        wr_reg(1'b1, 8'h03);
        nxt();
        push(K_WAKE, 12, 8'h00);
        push(K_IRQ, 9, 8'h01);
        // R10: mismatch sets flag with every enable off
        nxt(); periph = 1'b0; glob = 1'b0;
        wr_reg(1'b1, 8'h00);
        set_raw(2'b01);
        rd_chk(1'b1, 8'h01, 10);
        push(K_IRQ, 10, 8'h00);
        rd_chk(1'b0, 8'hB0, 10);
        // R2: turning off forces zero despite inverts
        wr_reg(1'b0, 8'h37);
        nxt();
        push(K_STAT, 2, 8'h00);
        rd_chk(1'b0, 8'h37, 2);
        nxt();
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule